// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Master

This block drives a three-wire synchronous serial link as a master: a clock output, a data output and a data input, with no select line. Each frame sends a transmit byte while the input line is sampled, so one byte comes back for each byte sent. A small register port sets up the transfer:

- which of two operation-clock enable strobes drives the transfer clock
- a clock divider
- frame length of 7 or 8 bits
- bit order
- clock polarity and phase
- whether the interrupt marks the end of a frame or an empty transmit buffer

Software writes the divider and the transmit byte together into one 16-bit data register, and that write starts a frame. Each half-period of the serial clock lasts divider+1 enabled operation-clock cycles. When the frame completes, the received byte is read from the low byte of the same register. In buffer-empty interrupt mode, the transmit byte moves into the shifter when a frame starts. A byte written while that frame is in flight is sent immediately afterwards, with no idle time on the clock.

Top module: `tw_serial_master`

## Requirements
- R1: After reset:
  - the serial clock rests high
  - data out is high
  - busy and interrupt are low
  - the data register reads 0
- R2: While no frame is in flight, the serial clock rests at the inverse of the polarity bit: high for polarity 0, low for polarity 1.
- R3: The clock-select bit picks enable strobe 0 or 1. Each serial-clock half-period inside a frame lasts (divider+1) cycles in which the selected strobe is high.
- R4: Each bit is one idle-level half followed by one active-level half when phase is 0, or the reverse when phase is 1. The input is sampled at the mid-bit edge. Data out changes only at bit boundaries and is valid at that edge.
- R5: The order bit selects MSB first (0) or LSB first (1), and the same order applies to transmit and receive.
- R6: The length bit selects 8 bits (1) or 7 bits (0). In 7-bit frames, bit 7 of the transmit byte is never sent, bit 7 of the received byte reads 0, and exactly 7 sample edges occur.
- R7: The data register (address 2) takes the divider in bits [15:9] and the transmit byte in [7:0]. A write starts a frame. A read returns the divider in [15:9], 0 in bit 8 and the last received byte in [7:0].
- R8: Busy rises on the second clock edge after the data-register write. It falls on the same edge that loads the received byte.
- R9: With interrupt source 0, the interrupt is a one-cycle pulse in the cycle in which busy has just cleared at frame end.
- R10: With interrupt source 1, the interrupt pulses when the transmit byte moves into the shifter. A byte written after that pulse follows the current frame with busy held high throughout.
- R11: Register map:
  - Address 0: bit 0 is clock select, bit 1 is interrupt source.
  - Address 1: bit 0 is length, bit 1 is order, bit 2 is phase, bit 3 is polarity.
  - Address 3 (read): bit 0 is busy, bit 1 is transmit buffer full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ck_en_i | input | 2 | Two operation-clock enable strobes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| busy_o | output | 1 | Frame in flight |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest condition to reach is the back-to-back case. The second byte has to be in the buffer at the exact cycle the previous frame ends, so that the end of one frame and the load of the next happen on the same edge. The bench reaches it in buffer-empty mode: it waits for the load interrupt and writes the next byte at once. It then checks that busy never drops before both frames' sample edges have been counted. A slave model watches the serial clock for sample edges and presents each receive bit at the next cycle. This lets all combinations of polarity, phase, order, length, clock source and two divider values be swept with expected bytes computed by masking.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 7;
  localparam int REG_W  = DIV_W + 1 + DATA_W;
  localparam int BIT_W  = $clog2(DATA_W);

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic len8;
  } frame_cfg_t;
endpackage

// File: rtl/tw_regs.sv
module tw_regs
  import tw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rx_i,
  input  logic              load_i,
  output logic              cks_o,
  output logic              irq_src_o,
  output frame_cfg_t        cfg_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cks_o     <= 1'b0;
      irq_src_o <= 1'b0;
      cfg_o     <= '0;
      div_o     <= '0;
      tx_byte_o <= '0;
      tx_full_o <= 1'b0;
    end else begin
      if (load_i) tx_full_o <= 1'b0;
      if (we_i) begin
        unique case (addr_i)
          2'd0: {irq_src_o, cks_o} <= wdata_i[1:0];
          2'd1: cfg_o <= frame_cfg_t'(wdata_i[3:0]);
          2'd2: begin
            div_o     <= wdata_i[REG_W-1 -: DIV_W];
            tx_byte_o <= wdata_i[DATA_W-1:0];
            tx_full_o <= 1'b1;  // write wins over same-cycle load
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      2'd0:    rdata_o = REG_W'({irq_src_o, cks_o});
      2'd1:    rdata_o = REG_W'(cfg_o);
      2'd2:    rdata_o = {div_o, 1'b0, rx_i};
      default: rdata_o = REG_W'({tx_full_o, busy_i});
    endcase
  end
endmodule

// File: rtl/tw_baud.sv
module tw_baud
  import tw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ck_en_i,
  input  logic             sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             half_tick_o
);
  logic             op_en;
  logic [DIV_W-1:0] cnt_q;

  assign op_en       = ck_en_i[sel_i];
  assign half_tick_o = run_i && op_en && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (op_en)     cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import tw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  frame_cfg_t        cfg_i,
  input  logic              tx_full_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              half_tick_i,
  input  logic              sdi_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sck_o,
  output logic              sdo_o
);
  logic              half_q;
  logic [BIT_W-1:0]  bitk_q, lenm1, idx;
  logic [DATA_W-1:0] tx_q, acc_q;
  logic              last;

  assign lenm1  = cfg_i.len8 ? BIT_W'(DATA_W-1) : BIT_W'(DATA_W-2);
  assign idx    = cfg_i.lsb_first ? bitk_q : lenm1 - bitk_q;
  assign last   = (bitk_q == lenm1);
  assign done_o = busy_o && half_q && half_tick_i && last;
  assign load_o = tx_full_i && (!busy_o || done_o);
  // second half is active for phase 0, first half for phase 1
  assign sck_o  = busy_o && (half_q ^ cfg_i.cpha) ? cfg_i.cpol : ~cfg_i.cpol;
  assign sdo_o  = busy_o ? tx_q[idx] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      half_q <= 1'b0;
      bitk_q <= '0;
      tx_q   <= '0;
      acc_q  <= '0;
      rx_o   <= '0;
    end else begin
      if (done_o) rx_o <= acc_q;
      if (load_o) begin
        busy_o <= 1'b1;
        half_q <= 1'b0;
        bitk_q <= '0;
        tx_q   <= tx_byte_i;
        acc_q  <= '0;
      end else if (done_o) begin
        busy_o <= 1'b0;
      end else if (busy_o && half_tick_i) begin
        if (!half_q) begin
          half_q     <= 1'b1;
          acc_q[idx] <= sdi_i;
        end else begin
          half_q <= 1'b0;
          bitk_q <= bitk_q + 1'b1;
        end
      end
    end
  end

  AST_START_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(tx_full_i));  // R8
  AST_END_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));  // R8
  AST_RX_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($past(cfg_i.len8) || !rx_o[DATA_W-1]));  // R6
endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
  import tw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ck_en_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             sck_o,
  output logic             sdo_o,
  input  logic             sdi_i,
  output logic             busy_o,
  output logic             irq_o
);
  logic              cks, irq_src, tx_full, load, done, half_tick;
  frame_cfg_t        cfg;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] tx_byte, rx;

  tw_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .busy_i(busy_o), .rx_i(rx), .load_i(load),
    .cks_o(cks), .irq_src_o(irq_src), .cfg_o(cfg), .div_o(div),
    .tx_byte_o(tx_byte), .tx_full_o(tx_full)
  );

  tw_baud u_baud (
    .clk_i, .rst_ni, .ck_en_i, .sel_i(cks), .div_i(div), .run_i(busy_o),
    .half_tick_o(half_tick)
  );

  tw_engine u_engine (
    .clk_i, .rst_ni, .cfg_i(cfg), .tx_full_i(tx_full), .tx_byte_i(tx_byte),
    .half_tick_i(half_tick), .sdi_i, .busy_o, .load_o(load), .done_o(done),
    .rx_o(rx), .sck_o, .sdo_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_src ? load : done;
  end

  AST_IDLE_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == ~cfg.cpol));  // R2
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);  // R9
endmodule

// File: tb/tb_tw_serial_master.sv
module tb_tw_serial_master;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  ck_en_i = 2'b01;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        sck_o, sdo_o, busy_o, irq_o;
  logic        sdi_i = 1'b1;

  tw_serial_master dut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cyc = 0, last_tr = 0, ntr = 0, r3_bad = 0;
  int edges = 0, irq_cnt = 0, irq_bad = 0;
  logic b_cpol = 0, b_cpha = 0, b_lsb = 0, b_len8 = 1, b_irq = 0;
  int   exp_half = 1;
  logic [7:0] slv [2];
  logic [7:0] txcap [2];
  logic prev_sck = 1'b1, b2b_on = 1'b0, gap = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int blen();
    return b_len8 ? 8 : 7;
  endfunction

  function automatic int ord(input int n);
    return b_lsb ? n : blen() - 1 - n;
  endfunction

  // slave model and waveform monitor
  always @(negedge clk_i) begin
    cyc++;
    ck_en_i[1] <= ~ck_en_i[1];
    if (rst_ni && sck_o != prev_sck) begin
      if (ntr >= 2 && (cyc - last_tr) != exp_half) r3_bad++;
      last_tr = cyc;
      ntr++;
      if (sck_o == (b_cpha ? ~b_cpol : b_cpol)) begin
        if (edges < 2 * blen()) txcap[edges / blen()][ord(edges % blen())] = sdo_o;
        edges++;
        if (edges < 2 * blen()) sdi_i = slv[edges / blen()][ord(edges % blen())];
      end
    end
    if (irq_o) begin
      irq_cnt++;
      if (!b_irq && busy_o) irq_bad++;                                  // R9
      if (b_irq && (!busy_o || (edges % blen()) != 0)) irq_bad++;       // R10
    end
    if (b2b_on && !busy_o && edges < 2 * blen()) gap = 1'b1;
    if (!busy_o) ntr = 0;
    prev_sck = sck_o;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic setup(input bit cks, input int div, input logic [3:0] cf, input bit irq);
    {b_cpol, b_cpha, b_lsb, b_len8} = cf;
    b_irq = irq;
    exp_half = (div + 1) * (cks ? 2 : 1);
    wr(2'd0, {14'b0, irq, cks});
    wr(2'd1, {12'b0, cf});
  endtask

  task automatic prime(input logic [7:0] s0, input logic [7:0] s1);
    slv[0] = s0; slv[1] = s1;
    txcap[0] = '0; txcap[1] = '0;
    edges = 0; irq_cnt = 0; irq_bad = 0; r3_bad = 0;
    sdi_i = s0[ord(0)];
  endtask

  task automatic frame(input bit cks, input int div, input logic [3:0] cf, input bit irq,
                       input logic [7:0] tx, input logic [7:0] sb);
    logic [15:0] d;
    logic [7:0]  m;
    setup(cks, div, cf, irq);
    prime(sb, 8'h00);
    m = b_len8 ? 8'hFF : 8'h7F;
    wr(2'd2, {7'(div), 1'b0, tx});
    wait (busy_o);
    wait (!busy_o);
    @(negedge clk_i);
    @(negedge clk_i);
    rd(2'd2, d);
    chk(d[7:0] == (sb & m), "R7 rx/R5 order", d[7:0], sb & m);
    chk(d[15:8] == {7'(div), 1'b0}, "R7 divider readback", d[15:8], {7'(div), 1'b0});
    chk(txcap[0] == (tx & m), "R5/R6 tx bits", txcap[0], tx & m);
    chk(edges == blen(), "R6 sample edges", edges, blen());
    chk(sck_o == ~b_cpol, "R2 idle sck", sck_o, ~b_cpol);
    chk(r3_bad == 0, "R3 half period", r3_bad, 0);
    chk(irq_cnt == 1 && irq_bad == 0, b_irq ? "R10 irq" : "R9 irq", irq_cnt, 1);
  endtask

  initial begin
    logic [15:0] d;
    slv[0] = '0; slv[1] = '0; txcap[0] = '0; txcap[1] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(sck_o == 1'b1, "R1 sck", sck_o, 1);
    chk(sdo_o == 1'b1, "R1 sdo", sdo_o, 1);
    chk(busy_o == 1'b0 && irq_o == 1'b0, "R1 busy/irq", {busy_o, irq_o}, 0);
    rd(2'd2, d);
    chk(d == 16'h0, "R1 data reg", d, 0);

    // R11 register readback
    setup(1'b1, 0, 4'b1010, 1'b1);
    rd(2'd0, d); chk(d == 16'h3, "R11 mode reg", d, 3);
    rd(2'd1, d); chk(d == 16'hA, "R11 cfg reg", d, 16'hA);
    chk(sck_o == 1'b0, "R2 idle low for polarity 1", sck_o, 0);

    // R8 busy timing, R11 status
    setup(1'b0, 1, 4'b0001, 1'b0);
    prime(8'h5A, 8'h00);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = {7'd1, 1'b0, 8'hC3};
    @(negedge clk_i);
    reg_we_i = 1'b0;
    rd(2'd3, d);
    chk(busy_o == 1'b0 && d[1:0] == 2'b10, "R8 not yet busy, R11 buffer full", d, 2);
    @(negedge clk_i);
    rd(2'd3, d);
    chk(busy_o == 1'b1 && d[1:0] == 2'b01, "R8 busy rises, R11 status", d, 1);
    wait (!busy_o);
    #1 rd(2'd2, d);
    chk(d[7:0] == 8'h5A, "R8 rx loaded with busy fall", d[7:0], 8'h5A);

    // R3 R4 R5 R6 R7 R9 R10 sweep
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 2; v++)
        for (int f = 0; f < 16; f++)
          frame(c[0], v * 3, f[3:0], c[0] ^ f[0],
                8'(8'hA5 ^ (f * 37) ^ (v * 8'h81)), 8'(8'h3C + f * 29 + v * 64 + c));

    // R10 back-to-back frames
    for (int f = 0; f < 4; f++) begin
      logic [7:0] m;
      setup(1'b0, 1, {f[1:0], 1'b0, f[0]}, 1'b1);
      prime(8'(8'h96 + f), 8'(8'hE1 - f));
      m = b_len8 ? 8'hFF : 8'h7F;
      gap = 1'b0;
      wr(2'd2, {7'd1, 1'b0, 8'(8'h0F + f)});
      wait (irq_o);
      b2b_on = 1'b1;
      wr(2'd2, {7'd1, 1'b0, 8'(8'hF0 - f)});
      wait (edges == 2 * blen());
      wait (!busy_o);
      b2b_on = 1'b0;
      @(negedge clk_i);
      rd(2'd2, d);
      chk(!gap, "R10 no idle between frames", gap, 0);
      chk(irq_cnt == 2 && irq_bad == 0, "R10 two load irqs", irq_cnt, 2);
      chk(txcap[0] == (8'(8'h0F + f) & m) && txcap[1] == (8'(8'hF0 - f) & m),
          "R10 tx both frames", {txcap[0], txcap[1]}, {8'(8'h0F + f) & m, 8'(8'hF0 - f) & m});
      chk(d[7:0] == (8'(8'hE1 - f) & m), "R10 rx second frame", d[7:0], 8'(8'hE1 - f) & m);
      chk(r3_bad == 0, "R4 half timing across chain", r3_bad, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule